// File: doc/BRIEF.md
# Composite-Field AES Byte Substitution Unit

This block computes the AES byte substitution, or its inverse, for a single byte using combinational logic only. No table of substitution values is stored anywhere. The forward direction takes the multiplicative inverse of the byte in GF(2^8) under the field polynomial x^8+x^4+x^3+x+1, then applies the AES affine transform. The inverse direction strips the affine transform first, then feeds the result through the same inverter. The forward function stands alone and takes any byte, so one copy can serve a data round or the key schedule.

The inverter works in the tower field GF((2^4)^2). The byte is first moved into that field with an 8x8 bit matrix and moved back afterwards with the inverse matrix. Both matrices, and the quadratic extension constant, are worked out at elaboration from two parameters: the nibble-field polynomial and the byte-field polynomial. A different nibble polynomial therefore builds a different but equivalent circuit. The unit has no clock, no state and no handshake. The output follows the byte and the direction select within the same time step, and a wrapper that needs a stream registers around it.

Top module: `sbox_cf`

## Requirements
- R1: With `inv_sel` = 0, `data_out` equals the AES forward substitution of `data_in`, which is the GF(2^8) inverse under polynomial 0x11B followed by the affine transform with constant 0x63. This holds for all 256 input values.
- R2: With `inv_sel` = 1, `data_out` equals the AES inverse substitution of `data_in`, which is the inverse affine transform followed by the GF(2^8) inverse. This holds for all 256 input values.
- R3: The direction select is encoded as 0 for forward and 1 for inverse. Changing only `inv_sel` for a fixed byte switches the output between the two functions.
- R4: Zero has no inverse and is treated as mapping to zero. So the forward output for 0x00 is 0x63, and the inverse output for 0x63 is 0x00.
- R5: Known points: forward 0x53 gives 0xED, forward 0x01 gives 0x7C, and inverse 0xED gives 0x53.
- R6: For every byte x, applying the inverse substitution to the forward substitution of x returns x.
- R7: The unit is purely combinational. A new input appears at `data_out` without any clock edge.
- R8: The result does not depend on the choice of nibble-field polynomial. A build with NIB_POLY = 0x19 (x^4+x^3+1) gives the same outputs as the default build with 0x13 (x^4+x+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Byte to substitute |
| inv_sel | input | 1 | 0 selects the forward substitution, 1 selects the inverse |
| data_out | output | 8 | Substituted byte |

## Verification
The bench builds two copies of the unit. One uses the default nibble polynomial 0x13. The other uses 0x19, which makes elaboration find a different extension constant, a different field root and different mapping matrices. Running all 256 bytes in both directions through both copies checks the elaboration-time search, not only one fixed set of matrices. The expected values come from a plain GF(2^8) reference with brute-force inversion, so the tower-field path is compared against arithmetic that shares none of its structure.

// File: rtl/sbox_cf_pkg.sv
package sbox_cf_pkg;

  // Multiply in GF(16); p is the full 5-bit reduction polynomial.
  function automatic logic [3:0] nib_mul(input logic [3:0] a, input logic [3:0] b,
                                         input logic [4:0] p);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = 4'h0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? p[3:0] : 4'h0);
    end
    return acc;
  endfunction

  // Multiply in GF((2^4)^2): element = hi*y + lo, where y^2 = y + lam.
  function automatic logic [7:0] pair_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [4:0] p, input logic [3:0] lam);
    logic [3:0] hh;
    logic [3:0] hi;
    logic [3:0] lo;
    hh = nib_mul(a[7:4], b[7:4], p);
    hi = hh ^ nib_mul(a[7:4], b[3:0], p) ^ nib_mul(a[3:0], b[7:4], p);
    lo = nib_mul(hh, lam, p) ^ nib_mul(a[3:0], b[3:0], p);
    return {hi, lo};
  endfunction

  // First nonzero lam for which y^2 + y + lam has no root in GF(16).
  function automatic logic [3:0] find_lambda(input logic [4:0] p);
    logic found;
    logic [3:0] lam;
    lam = 4'h0;
    for (int c = 15; c >= 1; c--) begin
      found = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((nib_mul(t[3:0], t[3:0], p) ^ t[3:0] ^ c[3:0]) == 4'h0) found = 1'b1;
      if (!found) lam = c[3:0];
    end
    return lam;
  endfunction

  // A root of the byte-field polynomial fp inside the tower field.
  function automatic logic [7:0] find_root(input logic [4:0] p, input logic [3:0] lam,
                                           input logic [8:0] fp);
    logic [7:0] acc;
    logic [7:0] pw;
    logic [7:0] root;
    root = 8'h00;
    for (int cand = 255; cand >= 2; cand--) begin
      acc = 8'h00;
      pw  = 8'h01;
      for (int k = 0; k < 9; k++) begin
        if (fp[k]) acc = acc ^ pw;
        pw = pair_mul(pw, cand[7:0], p, lam);
      end
      if (acc == 8'h00) root = cand[7:0];
    end
    return root;
  endfunction

  // Column i of a matrix is bits [8i+7:8i]; out = XOR of columns picked by x.
  function automatic logic [7:0] apply_matrix(input logic [63:0] m, input logic [7:0] x);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < 8; i++)
      if (x[i]) acc = acc ^ m[i*8 +: 8];
    return acc;
  endfunction

  // Byte field -> tower field: column i is root^i.
  function automatic logic [63:0] into_matrix(input logic [4:0] p, input logic [3:0] lam,
                                              input logic [8:0] fp);
    logic [63:0] m;
    logic [7:0]  r;
    logic [7:0]  pw;
    r  = find_root(p, lam, fp);
    pw = 8'h01;
    m  = 64'h0;
    for (int i = 0; i < 8; i++) begin
      m[i*8 +: 8] = pw;
      pw = pair_mul(pw, r, p, lam);
    end
    return m;
  endfunction

  // Tower field -> byte field, found by searching the preimage of each unit vector.
  function automatic logic [63:0] back_matrix(input logic [63:0] m);
    logic [63:0] b;
    b = 64'h0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (apply_matrix(m, a[7:0]) == (8'h01 << j)) b[j*8 +: 8] = a[7:0];
    return b;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int k);
    return (x << k) | (x >> (8 - k));
  endfunction

endpackage

// File: rtl/cf_lin_map.sv
module cf_lin_map #(
  parameter logic [63:0] MAT = 64'h8040201008040201
) (
  input  logic [7:0] vin,
  output logic [7:0] vout
);
  import sbox_cf_pkg::*;

  always_comb vout = apply_matrix(MAT, vin);
endmodule

// File: rtl/cf_nib_inv.sv
module cf_nib_inv #(
  parameter logic [4:0] NIB_POLY = 5'h13
) (
  input  logic [3:0] n_in,
  output logic [3:0] n_out
);
  import sbox_cf_pkg::*;

  logic [3:0] p2, p4, p8, p6;

  // n^14 = n^-1 for nonzero n, and 0 for 0.
  always_comb begin
    p2    = nib_mul(n_in, n_in, NIB_POLY);
    p4    = nib_mul(p2, p2, NIB_POLY);
    p8    = nib_mul(p4, p4, NIB_POLY);
    p6    = nib_mul(p4, p2, NIB_POLY);
    n_out = nib_mul(p8, p6, NIB_POLY);
  end

  always_comb begin
    if (n_in != 4'h0)
      AST_NIB_INV_UNIT: assert (nib_mul(n_in, n_out, NIB_POLY) == 4'h1) else $error("nibble inverse"); // R1
    else
      AST_NIB_ZERO: assert (n_out == 4'h0) else $error("nibble zero"); // R4
  end
endmodule

// File: rtl/cf_pair_inv.sv
module cf_pair_inv #(
  parameter logic [4:0] NIB_POLY = 5'h13,
  parameter logic [3:0] LAMBDA   = 4'h9
) (
  input  logic [7:0] t_in,
  output logic [7:0] t_out
);
  import sbox_cf_pkg::*;

  logic [3:0] hi, lo, delta, delta_inv;

  // inverse of hi*y+lo is (hi*d, (hi^lo)*d) with d = 1/(hi^2*lam + hi*lo + lo^2)
  always_comb begin
    hi    = t_in[7:4];
    lo    = t_in[3:0];
    delta = nib_mul(nib_mul(hi, hi, NIB_POLY), LAMBDA, NIB_POLY)
          ^ nib_mul(hi, lo, NIB_POLY) ^ nib_mul(lo, lo, NIB_POLY);
  end

  cf_nib_inv #(.NIB_POLY(NIB_POLY)) u_nib_inv (.n_in(delta), .n_out(delta_inv));

  always_comb t_out = {nib_mul(hi, delta_inv, NIB_POLY), nib_mul(hi ^ lo, delta_inv, NIB_POLY)};

  always_comb begin
    if (t_in != 8'h00)
      AST_PAIR_INV_UNIT: assert (pair_mul(t_in, t_out, NIB_POLY, LAMBDA) == 8'h01) else $error("pair inverse"); // R1
    else
      AST_PAIR_ZERO: assert (t_out == 8'h00) else $error("pair zero"); // R4
  end
endmodule

// File: rtl/cf_affine.sv
module cf_affine #(
  parameter bit         INVERSE = 1'b0,
  parameter logic [7:0] AFF_C   = 8'h63
) (
  input  logic [7:0] a_in,
  output logic [7:0] a_out
);
  import sbox_cf_pkg::*;

  generate
    if (INVERSE) begin : g_inv
      logic [7:0] x;
      always_comb begin
        x     = a_in ^ AFF_C;
        a_out = rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6);
      end
      always_comb
        if (a_in == AFF_C)
          AST_INV_AFF_CONST: assert (a_out == 8'h00) else $error("inverse affine const"); // R4
    end else begin : g_fwd
      always_comb
        a_out = a_in ^ rotl8(a_in, 1) ^ rotl8(a_in, 2) ^ rotl8(a_in, 3) ^ rotl8(a_in, 4) ^ AFF_C;
      always_comb
        if (a_in == 8'h00)
          AST_FWD_AFF_CONST: assert (a_out == AFF_C) else $error("forward affine const"); // R4
    end
  endgenerate
endmodule

// File: rtl/sbox_cf.sv
module sbox_cf #(
  parameter logic [4:0] NIB_POLY   = 5'h13,
  parameter logic [8:0] FIELD_POLY = 9'h11B
) (
  input  logic [7:0] data_in,
  input  logic       inv_sel,
  output logic [7:0] data_out
);
  import sbox_cf_pkg::*;

  localparam logic [3:0]  LAMBDA   = find_lambda(NIB_POLY);
  localparam logic [63:0] MAP_INTO = into_matrix(NIB_POLY, LAMBDA, FIELD_POLY);
  localparam logic [63:0] MAP_BACK = back_matrix(MAP_INTO);

  logic [7:0] pre_aff, inv_in, tower_in, tower_out, byte_inv, post_aff;

  cf_affine #(.INVERSE(1'b1)) u_pre (.a_in(data_in), .a_out(pre_aff));

  always_comb inv_in = inv_sel ? pre_aff : data_in;

  cf_lin_map  #(.MAT(MAP_INTO)) u_into (.vin(inv_in), .vout(tower_in));
  cf_pair_inv #(.NIB_POLY(NIB_POLY), .LAMBDA(LAMBDA)) u_inv (.t_in(tower_in), .t_out(tower_out));
  cf_lin_map  #(.MAT(MAP_BACK)) u_back (.vin(tower_out), .vout(byte_inv));

  cf_affine #(.INVERSE(1'b0)) u_post (.a_in(byte_inv), .a_out(post_aff));

  always_comb data_out = inv_sel ? byte_inv : post_aff;

  always_comb begin
    AST_MAP_ROUNDTRIP: assert (apply_matrix(MAP_BACK, tower_in) == inv_in) else $error("map roundtrip"); // R8
    if (inv_sel)
      AST_INV_FIXED: assert (data_in != 8'h63 || data_out == 8'h00) else $error("inverse of 0x63"); // R4
    else
      AST_FWD_FIXED: assert (data_in != 8'h00 || data_out == 8'h63) else $error("forward of 0x00"); // R4
  end
endmodule

// File: tb/tb_sbox_cf.sv
module tb_sbox_cf;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] din = 8'h00;
  logic       sel = 1'b0;
  logic [7:0] dout, dout_alt;

  sbox_cf dut (.data_in(din), .inv_sel(sel), .data_out(dout));
  sbox_cf #(.NIB_POLY(5'h19)) dut_alt (.data_in(din), .inv_sel(sel), .data_out(dout_alt));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cycles  = 0;

  logic [7:0] ref_fwd [256];
  logic [7:0] ref_inv [256];

  // {inv_sel, input, expected}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h53, 8'hED}, {1'b0, 8'h01, 8'h7C}, {1'b1, 8'hED, 8'h53},
    {1'b0, 8'h00, 8'h63}, {1'b1, 8'h63, 8'h00}, {1'b0, 8'hFF, 8'h16},
    {1'b1, 8'h16, 8'hFF}, {1'b0, 8'h10, 8'hCA}
  };

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] x, input int k);
    return (x << k) | (x >> (8 - k));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s in=%02h sel=%0b actual=%02h expected=%02h", req, din, sel, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel = s;
    din = d;
    #1;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // behavioural reference: brute-force inverse, then affine
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv;
      iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (gmul(x[7:0], y[7:0]) == 8'h01) iv = y[7:0];
      ref_fwd[x] = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) ref_inv[ref_fwd[x]] = x[7:0];

    // initial state: input 0, forward
    #1;
    chk("R4 initial", dout, 8'h63);

    // table walk
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][16], VEC[v][15:8]);
      chk("R5 vector", dout, VEC[v][7:0]);
      chk("R8 vector alt", dout_alt, VEC[v][7:0]);
    end

    // full sweeps, both builds
    for (int x = 0; x < 256; x++) begin
      drive(1'b0, x[7:0]);
      chk("R1 forward", dout, ref_fwd[x]);
      chk("R8 forward alt", dout_alt, ref_fwd[x]);
      drive(1'b1, x[7:0]);
      chk("R2 inverse", dout, ref_inv[x]);
      chk("R8 inverse alt", dout_alt, ref_inv[x]);
    end

    // round trip through the unit
    for (int x = 0; x < 256; x++) begin
      logic [7:0] f;
      drive(1'b0, x[7:0]);
      f = dout;
      drive(1'b1, f);
      chk("R6 roundtrip", dout, x[7:0]);
    end

    // R3: only the select changes
    drive(1'b0, 8'hA5);
    chk("R3 sel=0", dout, ref_fwd[8'hA5]);
    @(negedge clk);
    sel = 1'b1;
    #1;
    chk("R3 sel=1", dout, ref_inv[8'hA5]);

    // R4 zero corners
    drive(1'b0, 8'h00);
    chk("R4 fwd zero", dout, 8'h63);
    drive(1'b1, 8'h63);
    chk("R4 inv 0x63", dout, 8'h00);

    // R7: change between clock edges, check before next edge
    @(posedge clk);
    #0.5;
    sel = 1'b0;
    din = 8'h53;
    #0.5;
    chk("R7 no clock", dout, 8'hED);
    din = 8'h01;
    #0.5;
    chk("R7 no clock", dout, 8'h7C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule